// File: doc/BRIEF.md
# Private Interrupt Active-State Clear Register

This block keeps the active state of the 32 private interrupts that belong to one CPU interface. Indices 0 to 15 are software-generated interrupts and indices 16 to 31 are per-processor peripheral interrupts; both halves behave the same way. The acknowledge logic marks an interrupt active through a strobe and an interrupt number. Software reads the active state through a simple memory-mapped port and clears chosen interrupts by writing ones to their bits. Save and restore code uses this register to capture and then clear the active state.

Every access carries a secure/non-secure attribute. Whether an access can see or clear a bit depends on four things: a per-interrupt secure configuration vector, a global security-disable control, and one routing-mode enable for each security state. A hidden bit reads as zero and ignores writes. The register answers only to one aligned word offset in the per-CPU frame, and each CPU interface has its own instance. A pending vector comes in from outside. It is combined with the active bit into a per-interrupt state, and the read value comes from that state.

Top module: `prv_irq_active_bank`

## Requirements
- R1: After reset every active bit is 0 and the read data output is 0.
- R2: When `hw_act_vld` is high, the bit `hw_act_id` of `active_out` becomes 1 at the next clock edge. Bit positions are interrupt numbers 0 to 31.
- R3: A read to offset 0x380 returns, one cycle after the strobe, bit i = 1 when interrupt i is active, whether or not it is also pending, for every visible bit. A bit that is pending but not active reads as 0.
- R4: A write to offset 0x380 clears, at the next edge, each visible active bit whose write-data bit is 1. A 0 in the write data, or a 1 for an interrupt that is already inactive, changes nothing.
- R5: If an activate strobe and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R6: If the routing enable for an interrupt's security state is 0, that bit reads as 0 and ignores writes. `route_en_sec` covers interrupts whose `irq_is_secure` bit is 1, and `route_en_ns` covers those whose bit is 0.
- R7: With `sec_disable` = 0, a non-secure access (`bus_secure` = 0) reads 0 from every interrupt configured as secure and cannot clear it. A secure access can see and clear every bit.
- R8: With `sec_disable` = 1, a non-secure access sees and clears the bits of secure interrupts too.
- R9: A read to any offset other than 0x380 returns 0, and a write to any other offset leaves all active bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 16 | Byte offset within the per-CPU frame |
| bus_wdata | input | 32 | Write data, 1 = clear that interrupt |
| bus_secure | input | 1 | Access attribute, 1 = secure |
| bus_rdata | output | 32 | Registered read data |
| route_en_sec | input | 1 | Routing-mode enable for secure interrupts |
| route_en_ns | input | 1 | Routing-mode enable for non-secure interrupts |
| sec_disable | input | 1 | Global security-disable control |
| irq_is_secure | input | 32 | Per-interrupt secure configuration, 1 = secure |
| irq_pending | input | 32 | Per-interrupt pending state |
| hw_act_vld | input | 1 | Activate strobe from the acknowledge logic |
| hw_act_id | input | 5 | Interrupt number to activate |
| active_out | output | 32 | Current active state vector |

## Verification
Three results fall due one clock edge after their stimulus: read data after a read strobe, cleared bits on `active_out` after a write strobe, and a set bit after an activate strobe. Each bench task drives its strobe on the falling edge, waits for exactly one rising edge, samples one time unit later and drops the strobe at the next falling edge. No check can therefore see a value that is one cycle early or one cycle stale. The bench keeps its own model of the active vector and builds each expected visibility mask from the requirement text, not from the design.

// File: rtl/irqact_pkg.sv
package irqact_pkg;

  // Combined per-interrupt state used to form the read value
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_ACT_PEND = 2'b11
  } irq_state_e;

  function automatic irq_state_e form_state(input logic act, input logic pend);
    irq_state_e st;
    case ({act, pend})
      2'b00:   st = ST_IDLE;
      2'b01:   st = ST_PEND;
      2'b10:   st = ST_ACT;
      default: st = ST_ACT_PEND;
    endcase
    return st;
  endfunction

  // Read value: 1 when active, or active and pending
  function automatic logic state_reads_one(input irq_state_e st);
    return (st == ST_ACT) || (st == ST_ACT_PEND);
  endfunction

  // Whether one access may observe/modify one interrupt bit
  function automatic logic bit_visible(input logic is_sec,
                                       input logic acc_sec,
                                       input logic sec_dis,
                                       input logic rt_sec,
                                       input logic rt_ns);
    logic routed;
    logic allowed;
    routed  = is_sec ? rt_sec : rt_ns;
    allowed = acc_sec | sec_dis | ~is_sec;
    return routed & allowed;
  endfunction

endpackage

// File: rtl/irqact_decode.sv
module irqact_decode #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] REG_OFFSET = 16'h0380
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_hit,
  output logic              rd_miss,
  output logic              wr_hit
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

  logic match;
  // Exact compare: only the aligned word offset decodes
  assign match   = (addr == OFS);
  assign rd_hit  = rd & match;
  assign rd_miss = rd & ~match;
  assign wr_hit  = wr & match;
endmodule

// File: rtl/irqact_vis.sv
module irqact_vis
  import irqact_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] is_secure,
  input  logic               acc_secure,
  input  logic               sec_dis,
  input  logic               rt_sec,
  input  logic               rt_ns,
  output logic [NUM_IRQ-1:0] vis_mask
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    assign vis_mask[i] = bit_visible(is_secure[i], acc_secure, sec_dis, rt_sec, rt_ns);
  end
endmodule

// File: rtl/irqact_store.sv
module irqact_store #(
  parameter int NUM_IRQ = 32,
  localparam int ID_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_vld,
  input  logic [ID_W-1:0]    act_id,
  input  logic [NUM_IRQ-1:0] clr_vec,
  output logic [NUM_IRQ-1:0] set_vec,
  output logic [NUM_IRQ-1:0] active_q
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    assign set_vec[i] = act_vld && (act_id == ID_W'(i));

    // Set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          active_q[i] <= 1'b0;
      else if (set_vec[i]) active_q[i] <= 1'b1;
      else if (clr_vec[i]) active_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqact_readout.sv
module irqact_readout
  import irqact_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_hit,
  input  logic               rd_miss,
  input  logic [NUM_IRQ-1:0] active,
  input  logic [NUM_IRQ-1:0] pending,
  input  logic [NUM_IRQ-1:0] vis_mask,
  output logic [NUM_IRQ-1:0] rdata_q
);
  logic [NUM_IRQ-1:0] state_bits;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    assign state_bits[i] = state_reads_one(form_state(active[i], pending[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_hit)  rdata_q <= state_bits & vis_mask;
    else if (rd_miss) rdata_q <= '0;
  end
endmodule

// File: rtl/prv_irq_active_bank.sv
module prv_irq_active_bank #(
  parameter int          NUM_IRQ    = 32,
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] REG_OFFSET = 16'h0380,
  localparam int         ID_W       = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_IRQ-1:0] bus_wdata,
  input  logic               bus_secure,
  output logic [NUM_IRQ-1:0] bus_rdata,
  input  logic               route_en_sec,
  input  logic               route_en_ns,
  input  logic               sec_disable,
  input  logic [NUM_IRQ-1:0] irq_is_secure,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic               hw_act_vld,
  input  logic [ID_W-1:0]    hw_act_id,
  output logic [NUM_IRQ-1:0] active_out
);
  // Named internal events, observed by the bound checker
  logic               rd_hit;
  logic               rd_miss;
  logic               wr_hit;
  logic [NUM_IRQ-1:0] vis_mask;
  logic [NUM_IRQ-1:0] clr_vec;
  logic [NUM_IRQ-1:0] set_vec;

  irqact_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .rd_hit(rd_hit), .rd_miss(rd_miss), .wr_hit(wr_hit)
  );

  irqact_vis #(.NUM_IRQ(NUM_IRQ)) u_vis (
    .is_secure(irq_is_secure), .acc_secure(bus_secure), .sec_dis(sec_disable),
    .rt_sec(route_en_sec), .rt_ns(route_en_ns), .vis_mask(vis_mask)
  );

  assign clr_vec = {NUM_IRQ{wr_hit}} & bus_wdata & vis_mask;

  irqact_store #(.NUM_IRQ(NUM_IRQ)) u_store (
    .clk(clk), .rst_n(rst_n), .act_vld(hw_act_vld), .act_id(hw_act_id),
    .clr_vec(clr_vec), .set_vec(set_vec), .active_q(active_out)
  );

  irqact_readout #(.NUM_IRQ(NUM_IRQ)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_miss(rd_miss),
    .active(active_out), .pending(irq_pending), .vis_mask(vis_mask),
    .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/irqact_checker.sv
module irqact_checker #(
  parameter int  NUM_IRQ = 32,
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic               rd_hit,
  input logic               rd_miss,
  input logic               wr_hit,
  input logic [NUM_IRQ-1:0] vis_mask,
  input logic [NUM_IRQ-1:0] clr_vec,
  input logic [NUM_IRQ-1:0] set_vec,
  input logic [NUM_IRQ-1:0] bus_rdata,
  input logic [NUM_IRQ-1:0] active_out,
  input logic               hw_act_vld,
  input logic [ID_W-1:0]    hw_act_id
);
  AST_ACT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_act_vld |=> active_out[$past(hw_act_id)]); // R2

  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((active_out & ~$past(active_out) & ~$past(set_vec)) == '0)); // R2

  AST_CLR_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(active_out) & ~active_out & ~$past(clr_vec)) == '0)); // R4

  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_act_vld && wr_hit) |=> active_out[$past(hw_act_id)]); // R5

  AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> ((bus_rdata & ~$past(vis_mask)) == '0)); // R7

  AST_MISS_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> (bus_rdata == '0)); // R9

  AST_MISS_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_hit) |=> (($past(active_out) & ~active_out) == '0)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R3
endmodule

bind prv_irq_active_bank irqact_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .rd_hit(rd_hit), .rd_miss(rd_miss), .wr_hit(wr_hit),
  .vis_mask(vis_mask), .clr_vec(clr_vec), .set_vec(set_vec),
  .bus_rdata(bus_rdata), .active_out(active_out),
  .hw_act_vld(hw_act_vld), .hw_act_id(hw_act_id)
);

// File: tb/tb_prv_irq_active_bank.sv
module tb_prv_irq_active_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] OFS = 16'h0380;
  localparam logic [31:0] SEC_CFG = 32'h00FF_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_secure = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, active_out;
  logic        route_en_sec = 1'b1, route_en_ns = 1'b1, sec_disable = 1'b0;
  logic [31:0] irq_is_secure = SEC_CFG, irq_pending = '0;
  logic        hw_act_vld = 1'b0;
  logic [4:0]  hw_act_id = '0;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prv_irq_active_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .route_en_sec(route_en_sec), .route_en_ns(route_en_ns),
    .sec_disable(sec_disable), .irq_is_secure(irq_is_secure),
    .irq_pending(irq_pending), .hw_act_vld(hw_act_vld), .hw_act_id(hw_act_id),
    .active_out(active_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side restatement of which bits an access reaches
  function automatic logic [31:0] reach(input logic acc_sec);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      if (SEC_CFG[i]) m[i] = route_en_sec && (acc_sec || sec_disable);
      else            m[i] = route_en_ns;
    end
    return m;
  endfunction

  task automatic do_read(input logic [15:0] a, input logic sec, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; bus_secure = sec;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic sec, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_secure = sec; bus_wdata = d;
    @(posedge clk); #1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic activate(input logic [4:0] id);
    @(negedge clk); hw_act_vld = 1'b1; hw_act_id = id;
    @(posedge clk); #1;
    @(negedge clk); hw_act_vld = 1'b0;
    model[id] = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 active after reset", active_out, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
  endtask

  task automatic t_activate();
    activate(5'd0); activate(5'd15); activate(5'd16); activate(5'd31);
    activate(5'd2); activate(5'd20);
    check("R2 activate sets bits", active_out, model);
  endtask

  task automatic t_read();
    logic [31:0] d;
    irq_pending = ~model | 32'h0001_8000;
    do_read(OFS, 1'b1, d);
    check("R3 secure read of active and active+pending", d, model);
    irq_pending = '0;
  endtask

  task automatic t_clear();
    logic [31:0] d;
    do_write(OFS, 1'b1, 32'h8000_0001);
    model &= ~32'h8000_0001;
    check("R4 write one clears", active_out, model);
    do_write(OFS, 1'b1, 32'h0);
    check("R4 write zero no effect", active_out, model);
    do_write(OFS, 1'b1, 32'h0000_0100);
    check("R4 clear of inactive no effect", active_out, model);
    do_read(OFS, 1'b1, d);
    check("R4 readback after clears", d, model);
  endtask

  task automatic t_collide();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = OFS; bus_secure = 1'b1; bus_wdata = 32'h0000_0020;
    hw_act_vld = 1'b1; hw_act_id = 5'd5;
    @(posedge clk); #1;
    @(negedge clk); bus_wr = 1'b0; hw_act_vld = 1'b0;
    model[5] = 1'b1;
    check("R5 activate wins over clear", active_out, model);
  endtask

  task automatic t_secmask();
    logic [31:0] d;
    model = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) if (!active_out[i]) activate(5'(i));
    do_read(OFS, 1'b0, d);
    check("R7 nonsecure read hides secure bits", d, model & reach(1'b0));
    do_write(OFS, 1'b0, 32'hFFFF_FFFF);
    model &= ~reach(1'b0);
    check("R7 nonsecure write spares secure bits", active_out, model);
    do_read(OFS, 1'b1, d);
    check("R7 secure read sees all", d, model);
  endtask

  task automatic t_secdis();
    logic [31:0] d;
    sec_disable = 1'b1;
    do_read(OFS, 1'b0, d);
    check("R8 nonsecure read with security disabled", d, model);
    do_write(OFS, 1'b0, 32'h0000_0101);
    model &= ~32'h0000_0101;
    check("R8 nonsecure clear of secure bits", active_out, model);
    sec_disable = 1'b0;
  endtask

  task automatic t_route();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) if (!model[i]) activate(5'(i));
    route_en_ns = 1'b0;
    do_read(OFS, 1'b1, d);
    check("R6 nonsecure routing off hides bits", d, model & reach(1'b1));
    do_write(OFS, 1'b1, 32'hFFFF_FFFF);
    model &= ~reach(1'b1);
    check("R6 nonsecure routing off ignores writes", active_out, model);
    route_en_ns = 1'b1; route_en_sec = 1'b0;
    for (int i = 0; i < 32; i++) if (!model[i]) activate(5'(i));
    do_read(OFS, 1'b1, d);
    check("R6 secure routing off hides bits", d, model & reach(1'b1));
    do_write(OFS, 1'b1, 32'hFFFF_FFFF);
    model &= ~reach(1'b1);
    check("R6 secure routing off ignores writes", active_out, model);
    route_en_sec = 1'b1;
  endtask

  task automatic t_miss();
    logic [31:0] d;
    do_read(OFS + 16'h4, 1'b1, d);
    check("R9 read at other offset is zero", d, 32'h0);
    do_write(OFS - 16'h4, 1'b1, 32'hFFFF_FFFF);
    check("R9 write at other offset ignored", active_out, model);
    do_write(OFS + 16'h1, 1'b1, 32'hFFFF_FFFF);
    check("R9 unaligned write ignored", active_out, model);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_activate();
    t_read();
    t_clear();
    t_collide();
    t_secmask();
    t_secdis();
    t_route();
    t_miss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule